// File: doc/BRIEF.md
# PCI Read Parity Abort Controller

This block runs the data phase of a PCI target read that is served from a 64-bit system memory. For each accepted read it asks memory for a full doubleword and checks all eight byte-parity bits. It then drives one 32-bit half onto AD, chosen by PCI address bit 2. The bus parity bit for that data phase follows one clock later.

When any byte of the fetched doubleword fails its parity check, the data phase still completes with TRDY#. On the next clock the block drives the inverted parity value, and on the clock after that it target-aborts. The failing PCI address is captured in an error address register. The block raises an interrupt request and holds an active-low memory-parity-error flag. From then on every read request is target-aborted at once, without touching memory, until the host CPU strobes a read of the error address register.

A read whose translated address lies outside installed memory gets the same immediate abort, and nothing is logged for it. Address decode, arbitration and DRAM timing belong to neighbouring logic. The memory side is a plain request/valid handshake.

Top module: `pcipar_abort_ctl`

## Requirements
- R1: After reset, trdy_n, stop_n and devsel_n are high, par is 0, mem_req is 0, mpe_n is high, irq is low and err_addr is 0.
- R2: A request accepted while idle, in range and not locked raises mem_req on the next cycle. mem_req stays high until the cycle in which mem_valid is sampled high.
- R3: In the cycle after mem_valid is sampled, trdy_n and devsel_n are low for exactly one cycle. ad carries mem_data[63:32] when request address bit 2 is 1, and mem_data[31:0] when it is 0.
- R4: On a clean read, in the cycle after the data phase, par equals the XOR of all bits of ad[31:0] and of the captured cbe_n[3:0] (even parity), trdy_n is high and devsel_n is low. In the cycle after that the block is idle with devsel_n high.
- R5: Memory parity is even per byte: bit i of mem_par is correct when it equals the XOR of mem_data[8i+7:8i]. A mismatch in any of the eight lanes is a parity error, including lanes of the half that is not put on ad.
- R6: On a parity error the data phase of R3 still takes place. The next cycle drives par as the inverse of the R4 value, with devsel_n low. The cycle after that has stop_n low, devsel_n high and trdy_n high for one cycle.
- R7: From the data phase of a parity error, mpe_n is low and irq is high, and err_addr holds the PCI address of the failing read. err_addr changes at no other time.
- R8: While mpe_n is low, an accepted request gets stop_n low with devsel_n and trdy_n high on the next cycle, for one cycle. mem_req stays low and err_addr is unchanged.
- R9: A request with in_range low gets the abort of R8, and mem_req, mpe_n, irq and err_addr are left unchanged.
- R10: An err_rd pulse while locked returns mpe_n high and irq low on the next cycle. Reads after that are served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Pulse: a decoded memory read asks for its data phase |
| rd_addr | input | 32 | PCI address of the read |
| rd_cbe_n | input | 4 | Byte enables (active low) of the data phase |
| in_range | input | 1 | Translated address lies inside installed memory |
| mem_req | output | 1 | Doubleword fetch request to memory |
| mem_valid | input | 1 | Memory returns the doubleword this cycle |
| mem_data | input | 64 | Fetched doubleword |
| mem_par | input | 8 | Even parity bit per byte of mem_data |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop, active low |
| devsel_n | output | 1 | Device select, active low |
| ad | output | 32 | Selected data word |
| par | output | 1 | Bus parity for the previous data phase |
| mpe_n | output | 1 | Memory parity error flag, active low |
| irq | output | 1 | Interrupt request to the host CPU |
| err_rd | input | 1 | CPU read strobe of the error address register |
| err_addr | output | 32 | Address of the last failing read |

## Verification
The assertions assume that rd_start is pulsed only while the block is idle. They also assume that mem_valid is raised only while mem_req is high and stays high for a single cycle. The stimulus keeps to both rules by issuing one read at a time and waiting until the block returns to idle. Its memory model answers once per request after a random latency of zero to three cycles. The CPU strobe is issued only between reads, so a clear never meets a freshly detected error in the same cycle.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_ABORT = 3'd4
  } seq_state_t;

  // Bus parity: even parity over the data word and byte enables.
  function automatic logic bus_even_par(input logic [31:0] word, input logic [3:0] be_n);
    return (^word) ^ (^be_n);
  endfunction

endpackage

// File: rtl/pcipar_lane_chk.sv
module pcipar_lane_chk #(
  parameter int DW = 64,
  localparam int LANES = DW / 8
) (
  input  logic [DW-1:0]    data,
  input  logic [LANES-1:0] lane_par,
  output logic [LANES-1:0] lane_bad,
  output logic             any_bad
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = (^data[g*8 +: 8]) ^ lane_par[g];
  end
  assign any_bad = |lane_bad;
endmodule

// File: rtl/pcipar_word_sel.sv
module pcipar_word_sel #(
  parameter int DW = 64,
  parameter int WW = 32,
  localparam int NWORD = DW / WW,
  localparam int SELW = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic [DW-1:0]   dword,
  input  logic [SELW-1:0] sel,
  output logic [WW-1:0]   word
);
  if (NWORD > 1) begin : g_mux
    logic [WW-1:0] words [NWORD];
    for (genvar g = 0; g < NWORD; g++) begin : g_split
      assign words[g] = dword[g*WW +: WW];
    end
    assign word = words[sel];
  end else begin : g_pass
    logic unused_sel;
    assign unused_sel = ^sel;
    assign word = dword[WW-1:0];
  end
endmodule

// File: rtl/pcipar_err_log.sv
module pcipar_err_log #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_err,
  input  logic [AW-1:0] set_addr,
  input  logic          clr_err,
  output logic          locked,
  output logic [AW-1:0] err_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      err_addr <= '0;
    end else begin
      if (set_err) begin
        locked   <= 1'b1;
        err_addr <= set_addr;
      end else if (clr_err) begin
        locked   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcipar_abort_ctl.sv
module pcipar_abort_ctl #(
  parameter int ADDR_W = 32,
  parameter int DW     = 64,
  parameter int WW     = 32,
  localparam int LANES = DW / 8,
  localparam int BE_W  = WW / 8,
  localparam int NWORD = DW / WW,
  localparam int SELW  = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int SEL_LSB = $clog2(BE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BE_W-1:0]   rd_cbe_n,
  input  logic              in_range,
  output logic              mem_req,
  input  logic              mem_valid,
  input  logic [DW-1:0]     mem_data,
  input  logic [LANES-1:0]  mem_par,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              devsel_n,
  output logic [WW-1:0]     ad,
  output logic              par,
  output logic              mpe_n,
  output logic              irq,
  input  logic              err_rd,
  output logic [ADDR_W-1:0] err_addr
);
  import pcipar_pkg::*;

  seq_state_t state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   cbe_q;
  logic [WW-1:0]     ad_q;
  logic              perr_q;
  logic              locked;

  // Named internal events, visible to the checker
  logic rd_accept;
  logic data_take;
  logic perr_evt;
  logic any_bad;
  logic [LANES-1:0] lane_bad;
  logic [WW-1:0] sel_word;
  logic [SELW-1:0] word_sel;

  assign rd_accept = (state_q == ST_IDLE) && rd_start;
  assign data_take = (state_q == ST_WAIT) && mem_valid;
  assign perr_evt  = data_take && any_bad;

  if (NWORD > 1) begin : g_sel
    assign word_sel = addr_q[SEL_LSB +: SELW];
  end else begin : g_nosel
    assign word_sel = '0;
  end

  pcipar_lane_chk #(.DW(DW)) u_lane_chk (
    .data     (mem_data),
    .lane_par (mem_par),
    .lane_bad (lane_bad),
    .any_bad  (any_bad)
  );

  pcipar_word_sel #(.DW(DW), .WW(WW)) u_word_sel (
    .dword (mem_data),
    .sel   (word_sel),
    .word  (sel_word)
  );

  pcipar_err_log #(.AW(ADDR_W)) u_err_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_err  (perr_evt),
    .set_addr (addr_q),
    .clr_err  (err_rd),
    .locked   (locked),
    .err_addr (err_addr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rd_start) state_d = (locked || !in_range) ? ST_ABORT : ST_WAIT;
      ST_WAIT:  if (mem_valid) state_d = ST_DATA;
      ST_DATA:  state_d = ST_PAR;
      ST_PAR:   state_d = perr_q ? ST_ABORT : ST_IDLE;
      ST_ABORT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cbe_q   <= '0;
      ad_q    <= '0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rd_accept) begin
        addr_q <= rd_addr;
        cbe_q  <= rd_cbe_n;
      end
      if (data_take) begin
        ad_q   <= sel_word;
        perr_q <= any_bad;
      end
    end
  end

  assign mem_req  = (state_q == ST_WAIT);
  assign trdy_n   = (state_q != ST_DATA);
  assign devsel_n = !((state_q == ST_DATA) || (state_q == ST_PAR));
  assign stop_n   = (state_q != ST_ABORT);
  assign ad       = ad_q;
  assign par      = (state_q == ST_PAR) ? (bus_even_par(ad_q, cbe_q) ^ perr_q) : 1'b0;
  assign mpe_n    = !locked;
  assign irq      = locked;
endmodule

// File: rtl/pcipar_abort_ctl_chk.sv
module pcipar_abort_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          devsel_n,
  input logic          mpe_n,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_valid,
  input logic          err_rd,
  input logic [AW-1:0] err_addr,
  input logic          rd_accept,
  input logic          perr_evt
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> mem_req);

  // R3
  no_ready_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));

  // R6
  perr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> !trdy_n ##1 (trdy_n && !devsel_n) ##1 (!stop_n && devsel_n && trdy_n));

  // R7
  perr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> (!mpe_n && irq));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_evt |=> $stable(err_addr));

  // R8
  lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && !mpe_n) |=> (!stop_n && trdy_n && devsel_n && !mem_req));

  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !perr_evt) |=> (mpe_n && !irq));
endmodule

bind pcipar_abort_ctl pcipar_abort_ctl_chk #(.AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trdy_n    (trdy_n),
  .stop_n    (stop_n),
  .devsel_n  (devsel_n),
  .mpe_n     (mpe_n),
  .irq       (irq),
  .mem_req   (mem_req),
  .mem_valid (mem_valid),
  .err_rd    (err_rd),
  .err_addr  (err_addr),
  .rd_accept (rd_accept),
  .perr_evt  (perr_evt)
);

// File: tb/pcipar_abort_ctl_tb.sv
module pcipar_abort_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_start = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [3:0]  rd_cbe_n = '0;
  logic        in_range = 1'b0;
  logic        mem_req;
  logic        mem_valid = 1'b0;
  logic [63:0] mem_data = '0;
  logic [7:0]  mem_par = '0;
  logic        trdy_n, stop_n, devsel_n, par, mpe_n, irq;
  logic [31:0] ad;
  logic        err_rd = 1'b0;
  logic [31:0] err_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit mdl_lock = 0;
  logic [31:0] mdl_err_addr = '0;

  always #5 clk = ~clk;

  pcipar_abort_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_cbe_n(rd_cbe_n), .in_range(in_range), .mem_req(mem_req),
    .mem_valid(mem_valid), .mem_data(mem_data), .mem_par(mem_par),
    .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .ad(ad),
    .par(par), .mpe_n(mpe_n), .irq(irq), .err_rd(err_rd), .err_addr(err_addr)
  );

  // Byte parity computed by counting ones
  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += d[b*8+k];
      p[b] = ones[0];
    end
    return p;
  endfunction

  function automatic logic exp_bus_par(input logic [31:0] w, input logic [3:0] be);
    int ones = 0;
    for (int k = 0; k < 32; k++) ones += w[k];
    for (int k = 0; k < 4; k++) ones += be[k];
    return ones[0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle_chk(input string req);
    chk(stop_n && devsel_n && trdy_n, req, {29'd0, stop_n, devsel_n, trdy_n}, 32'h7);
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [3:0] be, input bit rng,
                         input logic [63:0] data, input logic [7:0] pbits, input int lat);
    bit bad;
    logic [31:0] word;
    logic [31:0] keep_err;
    bad = (pbits != good_par(data));
    word = addr[2] ? data[63:32] : data[31:0];
    keep_err = mdl_err_addr;
    @(negedge clk);
    rd_start = 1'b1; rd_addr = addr; rd_cbe_n = be; in_range = rng;
    @(negedge clk);
    rd_start = 1'b0;
    rd_addr = $urandom; rd_cbe_n = 4'($urandom);
    if (mdl_lock || !rng) begin
      // R8 / R9 immediate abort
      chk(!stop_n && devsel_n && trdy_n, mdl_lock ? "R8" : "R9",
          {29'd0, stop_n, devsel_n, trdy_n}, 32'h3);
      chk(!mem_req, mdl_lock ? "R8" : "R9", {31'd0, mem_req}, 32'd0);
      chk(err_addr == keep_err, mdl_lock ? "R8" : "R9", err_addr, keep_err);
      chk(mpe_n == !mdl_lock, "R9", {31'd0, mpe_n}, {31'd0, !mdl_lock});
      @(negedge clk);
      idle_chk("R8");
    end else begin
      chk(mem_req, "R2", {31'd0, mem_req}, 32'd1);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(mem_req && trdy_n, "R2", {30'd0, mem_req, trdy_n}, 32'h3);
      end
      mem_valid = 1'b1; mem_data = data; mem_par = pbits;
      @(negedge clk);
      mem_valid = 1'b0; mem_data = {$urandom, $urandom}; mem_par = 8'($urandom);
      chk(!trdy_n && !devsel_n && !mem_req, "R3", {29'd0, trdy_n, devsel_n, mem_req}, 32'd0);
      chk(ad == word, "R3", ad, word);
      if (bad) begin
        mdl_lock = 1; mdl_err_addr = addr;
        chk(!mpe_n && irq, "R7", {30'd0, mpe_n, irq}, 32'h1);
        chk(err_addr == addr, "R7", err_addr, addr);
      end else begin
        chk(err_addr == keep_err, "R7", err_addr, keep_err);
      end
      @(negedge clk);
      chk(par == (exp_bus_par(word, be) ^ bad), bad ? "R6" : "R4",
          {31'd0, par}, {31'd0, exp_bus_par(word, be) ^ bad});
      chk(trdy_n && !devsel_n && stop_n, bad ? "R6" : "R4",
          {29'd0, trdy_n, devsel_n, stop_n}, 32'h5);
      if (bad) begin
        @(negedge clk);
        chk(!stop_n && devsel_n && trdy_n, "R6", {29'd0, stop_n, devsel_n, trdy_n}, 32'h3);
      end
      @(negedge clk);
      idle_chk(bad ? "R6" : "R4");
    end
  endtask

  task automatic cpu_clear();
    @(negedge clk);
    err_rd = 1'b1;
    chk(err_addr == mdl_err_addr, "R7", err_addr, mdl_err_addr);
    @(negedge clk);
    err_rd = 1'b0;
    mdl_lock = 0;
    chk(mpe_n && !irq, "R10", {30'd0, mpe_n, irq}, 32'h2);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    logic [63:0] d;
    logic [31:0] a;
    void'($urandom(32'h5eed_1a2b));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(trdy_n && stop_n && devsel_n && !par && !mem_req && mpe_n && !irq,
        "R1", {25'd0, trdy_n, stop_n, devsel_n, par, mem_req, mpe_n, irq}, 32'h72);
    chk(err_addr == 0, "R1", err_addr, 0);
    rst_n = 1'b1;

    // Directed: clean lower and upper word (R3, R4)
    d = 64'hA5A5_0F0F_1234_5678;
    do_read(32'h8000_0010, 4'h0, 1, d, good_par(d), 0);
    do_read(32'h8000_0014, 4'h5, 1, d, good_par(d), 2);
    // R5: error only in the unselected upper half
    d = 64'hDEAD_BEEF_0000_FFFF;
    do_read(32'h8000_0020, 4'h3, 1, d, good_par(d) ^ 8'h80, 1);
    // R8: lockout abort, register kept
    do_read(32'h8000_0040, 4'h0, 1, d, good_par(d), 0);
    cpu_clear();
    // R10: normal service after clear
    do_read(32'h8000_0044, 4'hF, 1, d, good_par(d), 3);
    // R9: out of range, unlocked
    do_read(32'h8000_0048, 4'h0, 0, d, good_par(d), 0);
    chk(mpe_n && !irq, "R9", {30'd0, mpe_n, irq}, 32'h2);
    // R5: error in selected lower half, lane 0
    d = 64'h0123_4567_89AB_CDEF;
    do_read(32'h8000_0050, 4'h0, 1, d, good_par(d) ^ 8'h01, 0);
    cpu_clear();

    for (int t = 0; t < 400; t++) begin
      logic [7:0] pb;
      d = {$urandom, $urandom};
      a = $urandom;
      pb = good_par(d);
      if ($urandom_range(0, 7) == 0) pb[$urandom_range(0, 7)] ^= 1'b1;
      do_read(a, 4'($urandom), $urandom_range(0, 9) != 0, d, pb, $urandom_range(0, 3));
      if (mdl_lock && $urandom_range(0, 2) == 0) cpu_clear();
    end
    done = 1;
    summary();
  end
endmodule